// File: doc/BRIEF.md
# Double Column Hit Buffer

This block sits in the periphery of one double column of 2x80 pixel cells. When any cell fires, the column's fast OR starts a drain. The drain delivers the hit records of that event one per clock. Each record holds an 8-bit pixel index (0 to 159) and an 8-bit pulse height. The first hit of an event stamps the event with the current bunch-crossing count. The hit records go into a data store, and the first record of each event carries a start-of-event marker. The event's stamp and its hit count go into a separate stamp store once the last hit has been written.

Stored events wait for the first-level trigger latency. When an event reaches that age, the trigger input is sampled. If the trigger is high in exactly that cycle, the event is kept. It is then streamed out on a valid/ready port, one hit per handshake, with start and end flags and its stamp. Any event without a trigger at that moment is discarded along with its hits. When either store cannot take an event, the whole event is refused and counted as lost.

Top module: `dcol_hit_buffer`

## Requirements
- R1: After reset, `rd_valid` is 0, `lost_events` is 0, both stores are empty, and the crossing counter restarts at 0 in the first cycle after reset.
- R2: Hits of a kept event come out in arrival order with the pixel index and pulse height they had. `rd_first` is 1 only on the first hit of each event.
- R3: A drain beat is a cycle with `dr_valid` = 1, and `dr_last` = 1 marks the final beat of the event. All beats between one final beat and the next form a single event, even when idle cycles separate them.
- R4: An event stamped at crossing T is kept when `l1_trig` is 1 in the cycle where the crossing count equals T + LATENCY. A kept event is then presented on the read port.
- R5: An event with no trigger in its matching cycle is discarded and never presented. This includes a trigger one cycle early or one cycle late.
- R6: A new event whose first beat arrives while TS_DEPTH (12) events are stored is refused entirely. `lost_events` then increases by one at its final beat.
- R7: An event whose hits would exceed DATA_DEPTH (32) stored hits is refused entirely, and no partial hits are kept. `lost_events` increases by one at its final beat. An event of exactly 32 hits into an empty store is kept.
- R8: While `rd_valid` = 1 and `rd_ready` = 0, the read outputs hold steady. Each handshake moves to the next hit. `rd_last` is 1 on the event's final hit, and the event is freed after it.
- R9: `rd_stamp` carries the event's crossing stamp: the 8-bit crossing count, modulo 256, in the cycle of its first beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one cycle per bunch crossing |
| rst | input | 1 | Synchronous active-high reset |
| dr_valid | input | 1 | Drain beat present |
| dr_pix | input | 8 | Pixel index of the beat (0 to 159) |
| dr_ph | input | 8 | Pulse height of the beat |
| dr_last | input | 1 | Final beat of the event |
| l1_trig | input | 1 | First-level trigger |
| rd_valid | output | 1 | Read hit present |
| rd_ready | input | 1 | Consumer accepts the read hit |
| rd_pix | output | 8 | Pixel index of the read hit |
| rd_ph | output | 8 | Pulse height of the read hit |
| rd_first | output | 1 | Read hit starts its event |
| rd_last | output | 1 | Read hit ends its event |
| rd_stamp | output | 8 | Crossing stamp of the read event |
| lost_events | output | 16 | Count of refused events |

## Verification
The bench fires triggers one cycle early and one cycle late. A design that matched a window instead of the exact crossing would leak these events to the output. It fills the stamp store with thirteen single-hit events and pushes a 33-hit event and a 20+15 hit pair into the data store. A design that kept a partial event or lost count of occupancy would show extra hits or a wrong loss count. It applies pseudo-random back-pressure during readout, where a design that skipped or repeated hits would break ordering. It also sends an event with idle gaps between beats, where a design that started a new event on every gap would emit spurious start markers.

// File: rtl/dchb_pkg.sv
package dchb_pkg;

    localparam int PIX_CELLS = 160;
    localparam int PIX_W     = $clog2(PIX_CELLS);
    localparam int PH_W      = 8;
    localparam int TS_W      = 8;

    typedef struct packed {
        logic             marker;
        logic [PIX_W-1:0] pix;
        logic [PH_W-1:0]  ph;
    } hit_rec_t;

    // circular index addition, b may equal depth
    function automatic int unsigned wrap_add(int unsigned a, int unsigned b, int unsigned depth);
        int unsigned s;
        s = a + b;
        if (s >= depth) s = s - depth;
        return s;
    endfunction

endpackage

// File: rtl/dchb_bx_counter.sv
module dchb_bx_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] bx
);
    always_ff @(posedge clk) begin
        if (rst) bx <= '0;
        else     bx <= bx + W'(1);
    end
endmodule

// File: rtl/dchb_drain_ctrl.sv
module dchb_drain_ctrl import dchb_pkg::*; #(
    parameter int TS_DEPTH   = 12,
    parameter int DATA_DEPTH = 32,
    parameter int LOSS_W     = 16,
    localparam int TSC_W     = $clog2(TS_DEPTH + 1),
    localparam int DC_W      = $clog2(DATA_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit_vld,
    input  logic              hit_last,
    input  logic [TS_W-1:0]   bx,
    input  logic [TSC_W-1:0]  n_ts,
    input  logic [DC_W-1:0]   d_used,
    output logic              we,
    output logic [DC_W-1:0]   wr_off,
    output logic              commit,
    output logic [DC_W-1:0]   commit_cnt,
    output logic [TS_W-1:0]   commit_ts,
    output logic [LOSS_W-1:0] loss_count
);
    localparam logic [TSC_W-1:0] T_FULL = TSC_W'(TS_DEPTH);
    localparam logic [DC_W:0]    D_FULL = (DC_W + 1)'(DATA_DEPTH);

    logic            in_ev, dropping, first, room_t, room_d, accept, lost;
    logic [DC_W-1:0] wr_cnt;
    logic [TS_W-1:0] cur_ts;

    always_comb begin
        first      = hit_vld && !in_ev;
        room_t     = n_ts < T_FULL;
        room_d     = ({1'b0, d_used} + {1'b0, wr_cnt}) < D_FULL;
        accept     = hit_vld && (first ? room_t : !dropping) && room_d;
        lost       = hit_vld && hit_last && !accept;
        we         = accept;
        wr_off     = wr_cnt;
        commit     = accept && hit_last;
        commit_cnt = wr_cnt + DC_W'(1);
        commit_ts  = first ? bx : cur_ts;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_ev      <= 1'b0;
            dropping   <= 1'b0;
            wr_cnt     <= '0;
            cur_ts     <= '0;
            loss_count <= '0;
        end else if (hit_vld) begin
            in_ev    <= !hit_last;
            dropping <= !hit_last && !accept;
            if (hit_last)    wr_cnt <= '0;
            else if (accept) wr_cnt <= wr_cnt + DC_W'(1);
            if (first) cur_ts <= bx;
            if (lost)  loss_count <= loss_count + LOSS_W'(1);
        end
    end

    AST_LOSS_STEP: assert property (@(posedge clk) disable iff (rst)
        lost |=> loss_count == $past(loss_count) + LOSS_W'(1)); // R7
    AST_NO_PARTIAL: assert property (@(posedge clk) disable iff (rst)
        (hit_vld && in_ev && dropping) |-> !commit); // R7
    AST_ROOM_AT_COMMIT: assert property (@(posedge clk) disable iff (rst)
        commit |-> n_ts < T_FULL); // R6
endmodule

// File: rtl/dchb_event_store.sv
module dchb_event_store import dchb_pkg::*; #(
    parameter int TS_DEPTH   = 12,
    parameter int DATA_DEPTH = 32,
    parameter int LATENCY    = 136,
    localparam int TSC_W     = $clog2(TS_DEPTH + 1),
    localparam int DC_W      = $clog2(DATA_DEPTH + 1),
    localparam int TSI_W     = $clog2(TS_DEPTH),
    localparam int DI_W      = $clog2(DATA_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TS_W-1:0]   bx,
    input  logic              trig,
    input  logic              we,
    input  logic [DC_W-1:0]   wr_off,
    input  logic [PIX_W-1:0]  wr_pix,
    input  logic [PH_W-1:0]   wr_ph,
    input  logic              commit,
    input  logic [DC_W-1:0]   commit_cnt,
    input  logic [TS_W-1:0]   commit_ts,
    output logic [TSC_W-1:0]  n_ts,
    output logic [DC_W-1:0]   d_used,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PIX_W-1:0]  out_pix,
    output logic [PH_W-1:0]   out_ph,
    output logic              out_first,
    output logic              out_last,
    output logic [TS_W-1:0]   out_ts
);
    localparam logic [TS_W-1:0]  LAT_V  = TS_W'(LATENCY);
    localparam logic [TSC_W-1:0] T_FULL = TSC_W'(TS_DEPTH);
    localparam logic [DC_W-1:0]  D_FULL = DC_W'(DATA_DEPTH);

    // stamp store: one entry per committed event
    logic [TS_W-1:0] ts_val  [TS_DEPTH];
    logic [DC_W-1:0] ts_cnt  [TS_DEPTH];
    logic            ts_keep [TS_DEPTH];
    // hit store
    hit_rec_t        dmem    [DATA_DEPTH];

    logic [TSI_W-1:0] ts_head, ts_tail, ts_judge;
    logic [TSC_W-1:0] n_judged;
    logic [DI_W-1:0]  d_rd, d_base, waddr;
    logic [DC_W-1:0]  rd_idx, head_cnt, free_amt, add_amt;
    logic [TS_W-1:0]  age;
    logic             unj, judge_go, keep_set, head_rdy, discard, pop, ev_done;
    hit_rec_t         rec, wrec;

    always_comb begin
        unj      = n_ts != n_judged;
        age      = bx - ts_val[ts_judge];
        judge_go = unj && (age >= LAT_V);
        keep_set = trig && (age == LAT_V);
        head_rdy = n_judged != '0;
        head_cnt = ts_cnt[ts_head];
        out_valid = head_rdy && ts_keep[ts_head];
        discard  = head_rdy && !ts_keep[ts_head];
        pop      = out_valid && out_ready;
        out_last = rd_idx == head_cnt - DC_W'(1);
        ev_done  = discard || (pop && out_last);
        free_amt = discard ? head_cnt : (pop ? DC_W'(1) : '0);
        add_amt  = commit ? commit_cnt : '0;
        rec      = dmem[d_rd];
        out_pix  = rec.pix;
        out_ph   = rec.ph;
        out_first = rec.marker;
        out_ts   = ts_val[ts_head];
        waddr    = DI_W'(wrap_add(32'(d_base), 32'(wr_off), DATA_DEPTH));
        wrec     = '{marker: (wr_off == '0), pix: wr_pix, ph: wr_ph};
    end

    always_ff @(posedge clk) begin
        if (we) dmem[waddr] <= wrec;
        if (commit) begin
            ts_val[ts_tail] <= commit_ts;
            ts_cnt[ts_tail] <= commit_cnt;
        end
        if (judge_go) ts_keep[ts_judge] <= keep_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_head  <= '0;
            ts_tail  <= '0;
            ts_judge <= '0;
            n_ts     <= '0;
            n_judged <= '0;
            d_rd     <= '0;
            d_base   <= '0;
            d_used   <= '0;
            rd_idx   <= '0;
        end else begin
            n_ts     <= n_ts + TSC_W'(commit) - TSC_W'(ev_done);
            n_judged <= n_judged + TSC_W'(judge_go) - TSC_W'(ev_done);
            if (commit)   ts_tail  <= TSI_W'(wrap_add(32'(ts_tail), 1, TS_DEPTH));
            if (judge_go) ts_judge <= TSI_W'(wrap_add(32'(ts_judge), 1, TS_DEPTH));
            if (ev_done)  ts_head  <= TSI_W'(wrap_add(32'(ts_head), 1, TS_DEPTH));
            d_used <= d_used + add_amt - free_amt;
            if (commit) d_base <= DI_W'(wrap_add(32'(d_base), 32'(commit_cnt), DATA_DEPTH));
            if (discard)  d_rd <= DI_W'(wrap_add(32'(d_rd), 32'(head_cnt), DATA_DEPTH));
            else if (pop) d_rd <= DI_W'(wrap_add(32'(d_rd), 1, DATA_DEPTH));
            if (ev_done)  rd_idx <= '0;
            else if (pop) rd_idx <= rd_idx + DC_W'(1);
        end
    end

    AST_TS_OCC: assert property (@(posedge clk) disable iff (rst)
        n_ts <= T_FULL); // R6
    AST_DATA_OCC: assert property (@(posedge clk) disable iff (rst)
        d_used <= D_FULL); // R7
    AST_JUDGED_ORDER: assert property (@(posedge clk) disable iff (rst)
        n_judged <= n_ts); // R4
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(out_pix) && $stable(out_ph) && $stable(out_ts)); // R8
    AST_START_MARK: assert property (@(posedge clk) disable iff (rst)
        (out_valid && rd_idx == '0) |-> out_first); // R2
endmodule

// File: rtl/dcol_hit_buffer.sv
module dcol_hit_buffer import dchb_pkg::*; #(
    parameter int TS_DEPTH   = 12,
    parameter int DATA_DEPTH = 32,
    parameter int LATENCY    = 136,
    parameter int LOSS_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dr_valid,
    input  logic [PIX_W-1:0]  dr_pix,
    input  logic [PH_W-1:0]   dr_ph,
    input  logic              dr_last,
    input  logic              l1_trig,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [PIX_W-1:0]  rd_pix,
    output logic [PH_W-1:0]   rd_ph,
    output logic              rd_first,
    output logic              rd_last,
    output logic [TS_W-1:0]   rd_stamp,
    output logic [LOSS_W-1:0] lost_events
);
    localparam int TSC_W = $clog2(TS_DEPTH + 1);
    localparam int DC_W  = $clog2(DATA_DEPTH + 1);

    logic [TS_W-1:0]  bx, commit_ts;
    logic [TSC_W-1:0] n_ts;
    logic [DC_W-1:0]  d_used, wr_off, commit_cnt;
    logic             we, commit;

    dchb_bx_counter #(.W(TS_W)) bx_i (
        .clk(clk), .rst(rst), .bx(bx)
    );

    dchb_drain_ctrl #(
        .TS_DEPTH(TS_DEPTH), .DATA_DEPTH(DATA_DEPTH), .LOSS_W(LOSS_W)
    ) drain_i (
        .clk(clk), .rst(rst), .hit_vld(dr_valid), .hit_last(dr_last),
        .bx(bx), .n_ts(n_ts), .d_used(d_used), .we(we), .wr_off(wr_off),
        .commit(commit), .commit_cnt(commit_cnt), .commit_ts(commit_ts),
        .loss_count(lost_events)
    );

    dchb_event_store #(
        .TS_DEPTH(TS_DEPTH), .DATA_DEPTH(DATA_DEPTH), .LATENCY(LATENCY)
    ) store_i (
        .clk(clk), .rst(rst), .bx(bx), .trig(l1_trig), .we(we), .wr_off(wr_off),
        .wr_pix(dr_pix), .wr_ph(dr_ph), .commit(commit), .commit_cnt(commit_cnt),
        .commit_ts(commit_ts), .n_ts(n_ts), .d_used(d_used),
        .out_valid(rd_valid), .out_ready(rd_ready), .out_pix(rd_pix), .out_ph(rd_ph),
        .out_first(rd_first), .out_last(rd_last), .out_ts(rd_stamp)
    );
endmodule

// File: tb/dcol_hit_buffer_tb_top.sv
module dcol_hit_buffer_tb_top;
    import dchb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int LAT = 136;
    localparam int TSD = 12;
    localparam int DD  = 32;

    logic clk = 1'b0, rst = 1'b1;
    logic dr_valid = 1'b0, dr_last = 1'b0, l1_trig = 1'b0, rd_ready = 1'b1;
    logic [PIX_W-1:0] dr_pix = '0;
    logic [PH_W-1:0]  dr_ph = '0;
    logic rd_valid, rd_first, rd_last;
    logic [PIX_W-1:0] rd_pix;
    logic [PH_W-1:0]  rd_ph;
    logic [TS_W-1:0]  rd_stamp;
    logic [15:0]      lost_events;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcol_hit_buffer #(.TS_DEPTH(TSD), .DATA_DEPTH(DD), .LATENCY(LAT), .LOSS_W(16)) dut_i (
        .clk(clk), .rst(rst), .dr_valid(dr_valid), .dr_pix(dr_pix), .dr_ph(dr_ph),
        .dr_last(dr_last), .l1_trig(l1_trig), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_pix(rd_pix), .rd_ph(rd_ph), .rd_first(rd_first), .rd_last(rd_last),
        .rd_stamp(rd_stamp), .lost_events(lost_events)
    );

    int checks = 0, fails = 0;
    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // reference model state
    int mbx = 0, loss = 0, rd_idx = 0, cur_ts = 0, dut_beats = 0;
    int ev_ts[$], ev_cnt[$], ev_st[$];   // st: 0 waiting, 1 kept, 2 discarded
    int hq_pix[$], hq_ph[$], cp[$], cph[$], tq[$];
    bit in_ev = 0, dropping = 0, rdy_mode = 0;
    logic [7:0] lfsr = 8'h5a;

    always @(posedge clk) begin : model
        int used_d, nts, jj, age;
        bit hd_drop, hd_pop;
        if (rst) begin
            mbx = 0; loss = 0; rd_idx = 0; in_ev = 0; dropping = 0;
            ev_ts.delete(); ev_cnt.delete(); ev_st.delete();
            hq_pix.delete(); hq_ph.delete(); cp.delete(); cph.delete();
        end else begin
            if (rd_valid && rd_ready) dut_beats++;
            used_d = hq_pix.size();
            nts = ev_ts.size();
            hd_drop = nts > 0 && ev_st[0] == 2;
            hd_pop  = nts > 0 && ev_st[0] == 1 && rd_ready;
            jj = -1;
            for (int i = 0; i < nts; i++) if (jj < 0 && ev_st[i] == 0) jj = i;
            if (jj >= 0) begin
                age = mbx - ev_ts[jj];
                if (age == LAT) ev_st[jj] = l1_trig ? 1 : 2;
                else if (age > LAT) ev_st[jj] = 2;
            end
            if (hd_drop) begin
                for (int k = 0; k < ev_cnt[0]; k++) begin
                    void'(hq_pix.pop_front()); void'(hq_ph.pop_front());
                end
                void'(ev_ts.pop_front()); void'(ev_cnt.pop_front()); void'(ev_st.pop_front());
            end else if (hd_pop) begin
                void'(hq_pix.pop_front()); void'(hq_ph.pop_front());
                rd_idx++;
                if (rd_idx == ev_cnt[0]) begin
                    rd_idx = 0;
                    void'(ev_ts.pop_front()); void'(ev_cnt.pop_front()); void'(ev_st.pop_front());
                end
            end
            if (dr_valid) begin
                if (!in_ev) begin
                    cur_ts = mbx; cp.delete(); cph.delete();
                    dropping = !(nts < TSD && used_d < DD);
                end else if (!dropping && used_d + cp.size() >= DD) dropping = 1;
                if (!dropping) begin cp.push_back(dr_pix); cph.push_back(dr_ph); end
                in_ev = 1;
                if (dr_last) begin
                    if (dropping) loss++;
                    else begin
                        ev_ts.push_back(cur_ts); ev_cnt.push_back(cp.size()); ev_st.push_back(0);
                        foreach (cp[k]) begin hq_pix.push_back(cp[k]); hq_ph.push_back(cph[k]); end
                    end
                    in_ev = 0; dropping = 0;
                end
            end
            mbx++;
        end
    end

    always @(negedge clk) begin : cmp
        bit ev;
        if (!rst) begin
            ev = ev_ts.size() > 0 && ev_st[0] == 1;
            chk("R4 rd_valid", int'(rd_valid), int'(ev));
            if (ev) begin
                chk("R2 rd_pix", int'(rd_pix), hq_pix[0]);
                chk("R2 rd_ph", int'(rd_ph), hq_ph[0]);
                chk("R2 rd_first", int'(rd_first), int'(rd_idx == 0));
                chk("R8 rd_last", int'(rd_last), int'(rd_idx == ev_cnt[0] - 1));
                chk("R9 rd_stamp", int'(rd_stamp), ev_ts[0] % 256);
            end
            chk("R7 lost_events", int'(lost_events), loss);
        end
        l1_trig = 1'b0;
        foreach (tq[k]) if (tq[k] == mbx) l1_trig = 1'b1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rd_ready = rdy_mode ? lfsr[0] : 1'b1;
    end

    // drive one event; trig_off selects trigger timing relative to the match cycle
    task automatic send_event(int n, bit with_trig, int trig_off, int seed, int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dr_valid = 1'b1;
            dr_pix = PIX_W'((seed * 13 + i * 7) % PIX_CELLS);
            dr_ph  = PH_W'((seed * 29 + i * 37) % 256);
            dr_last = (i == n - 1);
            if (i == 0 && with_trig) tq.push_back(mbx + LAT + trig_off);
            if (gap > 0 && i != n - 1) begin
                @(negedge clk); dr_valid = 1'b0; dr_last = 1'b0;
                repeat (gap - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        dr_valid = 1'b0; dr_last = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rd_valid after reset", int'(rd_valid), 0);
        chk("R1 lost_events after reset", int'(lost_events), 0);
        chk("R1 stamp counter start", mbx, 1);

        // kept, discarded, kept
        send_event(3, 1, 0, 1, 0);
        idle(2);
        send_event(2, 0, 0, 2, 0);
        send_event(4, 1, 0, 3, 0);
        idle(LAT + 20);
        chk("R4 R5 beats after mixed events", dut_beats, 7);

        // back-pressure during readout
        b0 = dut_beats;
        rdy_mode = 1;
        send_event(5, 1, 0, 4, 0);
        send_event(3, 1, 0, 5, 0);
        idle(LAT + 60);
        rdy_mode = 0;
        idle(2);
        chk("R8 beats under back-pressure", dut_beats - b0, 8);

        // trigger one cycle late and one cycle early
        b0 = dut_beats;
        send_event(3, 1, 1, 6, 0);
        send_event(2, 1, -1, 7, 0);
        idle(LAT + 20);
        chk("R5 mistimed triggers give no output", dut_beats - b0, 0);

        // stamp store full
        b0 = dut_beats;
        for (int k = 0; k < TSD + 1; k++) send_event(1, 1, 0, 10 + k, 0);
        idle(LAT + 40);
        chk("R6 beats with full stamp store", dut_beats - b0, TSD);
        chk("R6 loss count", int'(lost_events), 1);

        // data store overflow, then an exactly full event
        b0 = dut_beats;
        send_event(DD + 1, 1, 0, 30, 0);
        send_event(DD, 1, 0, 31, 0);
        idle(LAT + 60);
        chk("R7 exactly full event kept", dut_beats - b0, DD);
        chk("R7 overflow counted", int'(lost_events), 2);

        // second event overflows behind stored hits
        b0 = dut_beats;
        send_event(20, 1, 0, 40, 0);
        send_event(15, 1, 0, 41, 0);
        idle(LAT + 60);
        chk("R7 no partial event", dut_beats - b0, 20);
        chk("R7 shared overflow counted", int'(lost_events), 3);

        // idle gaps inside one event
        b0 = dut_beats;
        send_event(3, 1, 0, 50, 2);
        idle(LAT + 20);
        chk("R3 gapped event read as one", dut_beats - b0, 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule